// File: doc/BRIEF.md
# Wake Event Controller for a Network Interface

This block handles power-management wake signalling for a network controller. It keeps a small register set through which the host can arm wake-up. That set holds the following:
- an enable for frame-based wake;
- an enable for the host power-management event;
- a two-bit device power state;
- a mask register for PHY interrupt sources;
- an interrupt enable;
- a status byte.

Two single-bit event inputs report activity. One comes from the MAC's wake-frame matcher and one from the PHY's energy-detect logic. Each event is caught in a sticky status bit.

When an armed wake source becomes active while the device sits in the deepest sleep state (code 3), with the event enable set, the block latches an event status. It then drives its active-low event output. That output stays low until the host clears the event enable or the event status. Any wake also sets an interrupt status bit, which reaches the interrupt pin only when its enable is set.

If the deepest state is entered while the event enable is clear, wake cannot be armed. In that case the block requests PHY reset and power-down, and it ignores wake frames.

The host reaches the block through a plain synchronous port:
- A write takes effect on the clock edge that samples the write strobe.
- A read returns data one cycle after the read strobe.

Status bits are write-one-to-clear. Other fields are read/write.

Top module: `pmwake_ctrl`

## Requirements
- R1: Host port. Write and read addresses are 0, 1, 2 and 3.
  - Address 0 holds frame-wake enable (bit 0), event enable (bit 1) and power state (bits 3:2). Its upper bits read 0.
  - Address 1 is status. Bit 0 is frame, bit 1 is energy, bit 2 is event, bit 3 is interrupt. All are write-one-to-clear.
  - Address 2 is the 8-bit PHY mask.
  - Address 3 holds the interrupt enable in bit 0.
  - Read data appears one cycle after the read strobe and holds until the next read.
- R2: A frame event sets the frame status bit, which stays set. Setting frame-wake enable while that bit is already set counts as a wake at once. In power state 3 with the event enable set, this drives the event output low.
- R3: A write-one-to-clear of the frame status bit (and of the energy bit) has no effect while the matching event input is high.
- R4: Once low, the event output stays low until the host clears the event enable or the event status bit.
- R5: While the power state is 3 and the event enable is clear, the PHY power-down and PHY reset outputs are high. In that condition a frame event leaves the frame status bit clear.
- R6: Any wake sets interrupt status. The interrupt output is high only while that status and the interrupt enable (address 3 bit 0) are both set.
- R7: A pulse on the exit-reset input clears the frame status bit.
- R8: An energy event sets energy status, and counts as a wake, only when PHY mask bit 7 is set.
- R9: After reset the event output is high, the interrupt and PHY request outputs are low, and every register reads 0.
- R10: In power states 0 to 2 a wake updates the status bits but leaves the event output high. Entering state 3 with the event enable set and a wake pending then raises the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after reg_re |
| frame_wake_i | input | 1 | Wake-frame match from the MAC |
| energy_evt_i | input | 1 | Energy-detect event from the PHY |
| exit_rst_i | input | 1 | Reset pulse issued when leaving a low-power state |
| pme_n_o | output | 1 | Active-low power-management event, registered |
| irq_o | output | 1 | Interrupt request |
| phy_pd_o | output | 1 | PHY general power-down request |
| phy_rst_o | output | 1 | PHY reset request |

## Verification
Several properties are checked on every cycle:
- The event output only rises after the enable or the status has gone.
- Event status only rises after a cycle in state 3 with the enable set.
- Energy status only rises under mask bit 7.
- A set frame bit survives while its input stays high.
- The exit reset clears the frame bit.
- PHY power-down never coincides with an asserted event.
- The interrupt pin follows its enable.

Some behaviour only the directed scenarios can show:
- the immediate wake when the frame-wake enable is set over a sticky status;
- the event raised on entry to state 3 with a wake pending;
- frames ignored under PHY power-down;
- the register layout and read latency.

// File: rtl/pmwake_pkg.sv
package pmwake_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pstate_e;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASK  = 2'd2;
    localparam logic [ADDR_W-1:0] A_IRQEN = 2'd3;

    localparam int CTL_WOL     = 0;
    localparam int CTL_PME     = 1;
    localparam int CTL_PS_LO   = 2;
    localparam int MASK_ENERGY = 7;
    localparam int STS_W       = 4;

    // frame is the least significant bit of the status byte
    typedef struct packed {
        logic irq;
        logic pme;
        logic energy;
        logic frame;
    } sts_t;

endpackage

// File: rtl/pmwake_regs.sv
module pmwake_regs
    import pmwake_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  sts_t          sts,
    output logic          wol_en,
    output logic          pme_en,
    output pstate_e       pstate,
    output logic          energy_mask,
    output logic          irq_en,
    output sts_t          clr,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic          wol_en;
        logic          pme_en;
        pstate_e       pstate;
        logic [DW-1:0] phy_mask;
        logic          irq_en;
        logic [DW-1:0] rdata;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;

        if (we) begin
            case (addr)
                A_CTRL: begin
                    cfg_d.wol_en = wdata[CTL_WOL];
                    cfg_d.pme_en = wdata[CTL_PME];
                    cfg_d.pstate = pstate_e'(wdata[CTL_PS_LO +: 2]);
                end
                A_STAT:  clr = sts_t'(wdata[STS_W-1:0]);
                A_MASK:  cfg_d.phy_mask = wdata;
                A_IRQEN: cfg_d.irq_en = wdata[0];
                default: ;
            endcase
        end

        if (re) begin
            cfg_d.rdata = '0;
            case (addr)
                A_CTRL: begin
                    cfg_d.rdata[CTL_WOL]        = cfg_q.wol_en;
                    cfg_d.rdata[CTL_PME]        = cfg_q.pme_en;
                    cfg_d.rdata[CTL_PS_LO +: 2] = cfg_q.pstate;
                end
                A_STAT:  cfg_d.rdata[STS_W-1:0] = sts;
                A_MASK:  cfg_d.rdata = cfg_q.phy_mask;
                A_IRQEN: cfg_d.rdata[0] = cfg_q.irq_en;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign wol_en      = cfg_q.wol_en;
    assign pme_en      = cfg_q.pme_en;
    assign pstate      = cfg_q.pstate;
    assign energy_mask = cfg_q.phy_mask[MASK_ENERGY];
    assign irq_en      = cfg_q.irq_en;
    assign rdata       = cfg_q.rdata;

endmodule

// File: rtl/pmwake_power.sv
module pmwake_power
    import pmwake_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e pstate,
    input  logic    pme_en,
    output logic    in_d3,
    output logic    pd_now,
    output logic    phy_pd,
    output logic    phy_rst
);

    typedef struct packed {
        logic pd;
        logic rst;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        in_d3     = (pstate == PS_D3);
        pd_now    = in_d3 && !pme_en;
        pwr_d.pd  = pd_now;
        pwr_d.rst = pd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= '0;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign phy_pd  = pwr_q.pd;
    assign phy_rst = pwr_q.rst;

endmodule

// File: rtl/pmwake_status.sv
module pmwake_status
    import pmwake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic energy_i,
    input  logic exit_rst_i,
    input  logic wol_en,
    input  logic pme_en,
    input  logic in_d3,
    input  logic pd_now,
    input  logic energy_mask,
    input  logic irq_en,
    input  sts_t clr,
    output sts_t sts,
    output logic pme_n,
    output logic irq
);

    typedef struct packed {
        sts_t sts;
        logic cond;
        logic pme_n;
        logic irq;
    } st_t;

    st_t  st_d, st_q;
    logic wake_src;
    logic wake_cond;

    always_comb begin
        st_d      = st_q;
        wake_src  = (wol_en && st_q.sts.frame) || st_q.sts.energy;
        wake_cond = wake_src && in_d3 && pme_en;

        // frame status: exit reset wins, then a detected frame, then a clear
        if (exit_rst_i) begin
            st_d.sts.frame = 1'b0;
        end else if (frame_i && !pd_now) begin
            st_d.sts.frame = 1'b1;
        end else if (clr.frame && !frame_i) begin
            st_d.sts.frame = 1'b0;
        end

        if (energy_i && energy_mask) begin
            st_d.sts.energy = 1'b1;
        end else if (clr.energy && !energy_i) begin
            st_d.sts.energy = 1'b0;
        end

        if (wake_src) begin
            st_d.sts.irq = 1'b1;
        end else if (clr.irq) begin
            st_d.sts.irq = 1'b0;
        end

        // event status latches on the first cycle the armed condition holds
        st_d.cond = wake_cond;
        if (wake_cond && !st_q.cond) begin
            st_d.sts.pme = 1'b1;
        end else if (clr.pme) begin
            st_d.sts.pme = 1'b0;
        end

        st_d.pme_n = !(st_d.sts.pme && pme_en);
        st_d.irq   = st_d.sts.irq && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.pme_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts   = st_q.sts;
    assign pme_n = st_q.pme_n;
    assign irq   = st_q.irq;

endmodule

// File: rtl/pmwake_ctrl.sv
module pmwake_ctrl
    import pmwake_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          frame_wake_i,
    input  logic          energy_evt_i,
    input  logic          exit_rst_i,
    output logic          pme_n_o,
    output logic          irq_o,
    output logic          phy_pd_o,
    output logic          phy_rst_o
);

    logic    cfg_wol;
    logic    cfg_pme_en;
    pstate_e cfg_pstate;
    logic    cfg_mask7;
    logic    cfg_irq_en;
    sts_t    sts_q;
    sts_t    clr_w;
    logic    in_d3;
    logic    pd_now;

    pmwake_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .re          (reg_re),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .sts         (sts_q),
        .wol_en      (cfg_wol),
        .pme_en      (cfg_pme_en),
        .pstate      (cfg_pstate),
        .energy_mask (cfg_mask7),
        .irq_en      (cfg_irq_en),
        .clr         (clr_w),
        .rdata       (reg_rdata)
    );

    pmwake_power u_power (
        .clk     (clk),
        .rst_n   (rst_n),
        .pstate  (cfg_pstate),
        .pme_en  (cfg_pme_en),
        .in_d3   (in_d3),
        .pd_now  (pd_now),
        .phy_pd  (phy_pd_o),
        .phy_rst (phy_rst_o)
    );

    pmwake_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_i     (frame_wake_i),
        .energy_i    (energy_evt_i),
        .exit_rst_i  (exit_rst_i),
        .wol_en      (cfg_wol),
        .pme_en      (cfg_pme_en),
        .in_d3       (in_d3),
        .pd_now      (pd_now),
        .energy_mask (cfg_mask7),
        .irq_en      (cfg_irq_en),
        .clr         (clr_w),
        .sts         (sts_q),
        .pme_n       (pme_n_o),
        .irq         (irq_o)
    );

endmodule

// File: rtl/pmwake_chk.sv
module pmwake_chk
    import pmwake_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    frame_i,
    input logic    energy_i,
    input logic    exit_rst_i,
    input logic    pme_en,
    input pstate_e pstate,
    input logic    mask7,
    input logic    irq_en,
    input sts_t    sts,
    input logic    pme_n,
    input logic    irq,
    input logic    phy_pd
);

    AST_PME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_n) |-> (!sts.pme || !$past(pme_en)));                    // R4

    AST_PME_SET_IN_D3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts.pme) |-> $past(pstate == PS_D3 && pme_en));              // R10

    AST_PD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        phy_pd |-> pme_n);                                                 // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));                                            // R6

    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts.frame && frame_i && !exit_rst_i) |=> sts.frame);              // R3

    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        exit_rst_i |=> !sts.frame);                                        // R7

    AST_ENERGY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts.energy) |-> $past(energy_i && mask7));                   // R8

endmodule

bind pmwake_ctrl pmwake_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_wake_i),
    .energy_i   (energy_evt_i),
    .exit_rst_i (exit_rst_i),
    .pme_en     (cfg_pme_en),
    .pstate     (cfg_pstate),
    .mask7      (cfg_mask7),
    .irq_en     (cfg_irq_en),
    .sts        (sts_q),
    .pme_n      (pme_n_o),
    .irq        (irq_o),
    .phy_pd     (phy_pd_o)
);

// File: tb/sim_pmwake_ctrl.sv
module sim_pmwake_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       frame_wake_i = 1'b0;
    logic       energy_evt_i = 1'b0;
    logic       exit_rst_i = 1'b0;
    logic       pme_n_o;
    logic       irq_o;
    logic       phy_pd_o;
    logic       phy_rst_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmwake_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_re       (reg_re),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .frame_wake_i (frame_wake_i),
        .energy_evt_i (energy_evt_i),
        .exit_rst_i   (exit_rst_i),
        .pme_n_o      (pme_n_o),
        .irq_o        (irq_o),
        .phy_pd_o     (phy_pd_o),
        .phy_rst_o    (phy_rst_o)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frame_wake_i = 1'b0;
        energy_evt_i = 1'b0;
        exit_rst_i = 1'b0;
        reg_we = 1'b0;
        reg_re = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_wake_i = 1'b1;
        @(negedge clk); frame_wake_i = 1'b0;
    endtask

    task automatic pulse_energy();
        @(negedge clk); energy_evt_i = 1'b1;
        @(negedge clk); energy_evt_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        chk("R9", "pme_n after reset", {7'd0, pme_n_o}, 8'h01);
        chk("R9", "irq after reset", {7'd0, irq_o}, 8'h00);
        chk("R9", "phy_pd after reset", {7'd0, phy_pd_o}, 8'h00);
        chk("R9", "phy_rst after reset", {7'd0, phy_rst_o}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R9", "register after reset", v, 8'h00);
        end
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h0E); rd(2'd0, v); chk("R1", "ctrl readback", v, 8'h0E);
        wr(2'd0, 8'hF1); rd(2'd0, v); chk("R1", "ctrl upper bits read zero", v, 8'h01);
        wr(2'd2, 8'hA5); rd(2'd2, v); chk("R1", "mask readback", v, 8'hA5);
        wr(2'd3, 8'hFF); rd(2'd3, v); chk("R1", "irq enable readback", v, 8'h01);
        idle(2);
        chk("R1", "rdata holds without read", reg_rdata, 8'h01);
    endtask

    task automatic t_frame_d3();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h0F);
        pulse_frame();
        idle(4);
        chk("R2", "pme_n after frame in D3", {7'd0, pme_n_o}, 8'h00);
        rd(2'd1, v); chk("R2", "status after wake", v, 8'h0D);
        wr(2'd1, 8'h01); idle(3);
        chk("R4", "pme_n held after frame clear", {7'd0, pme_n_o}, 8'h00);
        wr(2'd1, 8'h04); idle(2);
        chk("R4", "pme_n released by status clear", {7'd0, pme_n_o}, 8'h01);
        pulse_frame();
        idle(4);
        chk("R4", "pme_n on second wake", {7'd0, pme_n_o}, 8'h00);
        wr(2'd0, 8'h0D); idle(3);
        chk("R4", "pme_n released by enable clear", {7'd0, pme_n_o}, 8'h01);
    endtask

    task automatic t_sticky_wol();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h0E);
        pulse_frame(); idle(3);
        rd(2'd1, v); chk("R2", "frame sticky without wake enable", v, 8'h01);
        chk("R2", "no event without wake enable", {7'd0, pme_n_o}, 8'h01);
        wr(2'd0, 8'h0F); idle(4);
        chk("R2", "event when enable set over sticky status", {7'd0, pme_n_o}, 8'h00);
    endtask

    task automatic t_clear_blocked();
        logic [7:0] v;
        do_reset();
        @(negedge clk); frame_wake_i = 1'b1;
        idle(2);
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R3", "clear ignored while frame input high", v, 8'h01);
        @(negedge clk); frame_wake_i = 1'b0;
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R3", "clear works once input low", v, 8'h00);
    endtask

    task automatic t_pd();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h0D); idle(2);
        chk("R5", "phy power-down in D3 without enable", {7'd0, phy_pd_o}, 8'h01);
        chk("R5", "phy reset in D3 without enable", {7'd0, phy_rst_o}, 8'h01);
        pulse_frame(); idle(3);
        rd(2'd1, v); chk("R5", "frame ignored under power-down", v, 8'h00);
        chk("R5", "no event under power-down", {7'd0, pme_n_o}, 8'h01);
        wr(2'd0, 8'h00); idle(2);
        chk("R5", "phy power-down released", {7'd0, phy_pd_o}, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h01);
        pulse_frame(); idle(3);
        chk("R6", "irq masked", {7'd0, irq_o}, 8'h00);
        rd(2'd1, v); chk("R6", "irq status set", v, 8'h09);
        chk("R10", "no event in D0", {7'd0, pme_n_o}, 8'h01);
        wr(2'd3, 8'h01); idle(2);
        chk("R6", "irq asserted when enabled", {7'd0, irq_o}, 8'h01);
        wr(2'd1, 8'h01); idle(1);
        wr(2'd1, 8'h08); idle(2);
        chk("R6", "irq released after clear", {7'd0, irq_o}, 8'h00);
        rd(2'd1, v); chk("R6", "status cleared", v, 8'h00);
    endtask

    task automatic t_exit_rst();
        logic [7:0] v;
        do_reset();
        pulse_frame(); idle(1);
        rd(2'd1, v); chk("R7", "frame set before exit reset", v, 8'h01);
        @(negedge clk); exit_rst_i = 1'b1;
        @(negedge clk); exit_rst_i = 1'b0;
        rd(2'd1, v); chk("R7", "frame cleared by exit reset", v, 8'h00);
    endtask

    task automatic t_energy();
        logic [7:0] v;
        do_reset();
        wr(2'd2, 8'h7F);
        pulse_energy(); idle(2);
        rd(2'd1, v); chk("R8", "energy ignored without mask bit 7", v, 8'h00);
        wr(2'd2, 8'h80);
        pulse_energy(); idle(3);
        rd(2'd1, v); chk("R8", "energy wake with mask bit 7", v, 8'h0A);
    endtask

    task automatic t_not_d3();
        logic [7:0] v;
        do_reset();
        wr(2'd0, 8'h0B);
        pulse_frame(); idle(4);
        rd(2'd1, v); chk("R10", "status in D2", v, 8'h09);
        chk("R10", "no event in D2", {7'd0, pme_n_o}, 8'h01);
        wr(2'd0, 8'h0F); idle(4);
        chk("R10", "event on entry to D3 with wake pending", {7'd0, pme_n_o}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_frame_d3();
        t_sticky_wol();
        t_clear_blocked();
        t_pd();
        t_irq();
        t_exit_rst();
        t_energy();
        t_not_d3();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule